// File: doc/BRIEF.md
# Per-Core Cache Utility Monitor

This block watches the access stream of one core and estimates how many hits that core would get from a shared cache of any way count. It keeps a shadow directory of tags for a small sampled group of sets. Each sampled set is kept in strict recency order, as if the core owned every way of the shared cache. Accesses from other cores never reach this directory, so the recency order reflects only this core's behaviour.

On every qualifying access the shadow set is searched. A hit adds one to the counter for the recency position where the tag was found. The tag then moves to the most recently used slot. A miss evicts the least recently used tag and inserts the new tag at the top. Because LRU is a stack algorithm, the hits the core would see with n ways equal the sum of the first n counters. A partitioning engine outside this block can read that sum directly.

The counters saturate. A clear pulse restarts them at the beginning of each measurement epoch and leaves the shadow tags in place.

Top module: `cache_utility_monitor`

## Requirements
- R1: After reset, every hit counter reads zero and every shadow set is empty, so the first access to any set misses.
- R2: The set index is `acc_line[SKIP_W+SLOT_W-1:0]`. An access is sampled only when its low SKIP_W bits (5 by default) are all zero. The upper SLOT_W bits then pick one of SAMP_SETS shadow sets. Unsampled accesses change neither the counters nor any recency order.
- R3: An access is processed only when `acc_valid` and `acc_own` are both high. With `acc_own` low, the access has no effect.
- R4: A hit at recency position p (0 = most recent, WAYS-1 = least recent) adds one to counter p. That tag moves to position 0, and the tags at positions 0 to p-1 each move down one place.
- R5: On a miss, the tag at position WAYS-1 is dropped and the new tag enters at position 0. No counter changes. Tags within one set are unique.
- R6: Each shadow set keeps its own recency order, and accesses to one set do not affect another.
- R7: Counters stop at 2^CNT_W-1, and further hits leave them there.
- R8: A high `cnt_clear` sets all counters to zero at the next edge. It wins over a hit in the same cycle, and it does not remove any shadow tags.
- R9: Each access is resolved in one cycle. The result shows on `hit_cnt` after that edge, and an access in the very next cycle sees the updated order.
- R10: Counter p sits in `hit_cnt[p*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_own | input | 1 | Access belongs to the monitored core |
| acc_line | input | LINE_W | Cache line address (tag above set index) |
| cnt_clear | input | 1 | Zero all hit counters |
| hit_cnt | output | WAYS*CNT_W | Per-recency-position hit counters, packed |

## Verification
The case that is hardest to reach from the ports is a hit deep in the stack after evictions have already reordered a set. The expected position depends on the whole access history of that set. The bench fills a set to capacity, reaches back to its oldest tag, forces misses to evict, and then hits tags whose positions it works out by hand. Back-to-back hits in consecutive cycles alternate two tags, which catches a stale read of the order. Ignored accesses use a tag that is already present, and a later real hit confirms that its position did not move.

// File: rtl/cache_utility_monitor.sv
module cache_utility_monitor #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 5,
  parameter int SKIP_W    = 5,
  parameter int WAYS      = 16,
  parameter int CNT_W     = 16,
  parameter int LINE_W    = TAG_W + SLOT_W + SKIP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_own,
  input  logic [LINE_W-1:0]       acc_line,
  input  logic                    cnt_clear,
  output logic [WAYS*CNT_W-1:0]   hit_cnt
);
  localparam int SAMP_SETS = 1 << SLOT_W;
  localparam int POS_W     = $clog2(WAYS);

  logic [TAG_W-1:0] tags [SAMP_SETS][WAYS];
  logic [WAYS-1:0]  vld  [SAMP_SETS];
  logic [CNT_W-1:0] cnt  [WAYS];

  wire [TAG_W-1:0]  tag     = acc_line[LINE_W-1 -: TAG_W];
  wire [SLOT_W-1:0] slot    = acc_line[SKIP_W +: SLOT_W];
  wire              sampled = (acc_line[SKIP_W-1:0] == '0);
  wire              take    = acc_valid && acc_own && sampled;

  logic [WAYS-1:0]  match;
  logic             hit;
  logic [POS_W-1:0] hpos;
  logic [POS_W-1:0] lim;

  always_comb begin
    hpos = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = vld[slot][w] && (tags[slot][w] == tag);
    for (int w = WAYS-1; w >= 0; w--)
      if (match[w]) hpos = w[POS_W-1:0];
    hit = |match;
    lim = hit ? hpos : POS_W'(WAYS-1);
  end

  always_ff @(posedge clk) begin
    if (take) begin
      tags[slot][0] <= tag;
      for (int w = 1; w < WAYS; w++)
        if (w <= int'(lim)) tags[slot][w] <= tags[slot][w-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SAMP_SETS; s++) vld[s] <= '0;
    end else if (take && !hit) begin
      vld[slot] <= {vld[slot][WAYS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clear) begin
      for (int w = 0; w < WAYS; w++) cnt[w] <= '0;
    end else if (take && hit && (cnt[hpos] != '1)) begin
      cnt[hpos] <= cnt[hpos] + 1'b1;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_out
    assign hit_cnt[g*CNT_W +: CNT_W] = cnt[g];

    p_no_decrease_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clear |=> cnt[g] >= $past(cnt[g]));
  end

  p_unique_tags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  p_miss_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit && !cnt_clear) |=> $stable(hit_cnt));

  p_ignored_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !cnt_clear) |=> $stable(hit_cnt));

  p_mru_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vld[$past(slot)][0] && (tags[$past(slot)][0] == $past(tag)));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (hit_cnt == '0));

endmodule

// File: tb/tb_cache_utility_monitor.sv
module tb_cache_utility_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 16;
  localparam int CNT_W = 5;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic acc_valid = 0;
  logic acc_own = 0;
  logic [25:0] acc_line = '0;
  logic cnt_clear = 0;
  logic [WAYS*CNT_W-1:0] hit_cnt;

  int checks = 0;
  int errors = 0;
  int expc [WAYS];
  bit done = 0;

  cache_utility_monitor #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_own(acc_own),
    .acc_line(acc_line), .cnt_clear(cnt_clear), .hit_cnt(hit_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic acc(input int t, input int s, input bit own = 1, input int low = 0);
    @(negedge clk);
    acc_valid = 1; acc_own = own; cnt_clear = 0;
    acc_line = {t[15:0], s[4:0], low[4:0]};
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; cnt_clear = 0;
  endtask

  task automatic bump(input int p);
    if (expc[p] < MAXC) expc[p]++;
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < WAYS; p++) begin
      checks++;
      if (int'(hit_cnt[p*CNT_W +: CNT_W]) != expc[p]) begin
        errors++;
        $display("FAIL %s counter %0d actual %0d expected %0d", req, p,
                 hit_cnt[p*CNT_W +: CNT_W], expc[p]);
      end
    end
  endtask

  task automatic t_reset();
    for (int p = 0; p < WAYS; p++) expc[p] = 0;
    idle();
    check_all("R1 reset");
    acc(0, 3);
    idle();
    check_all("R1 empty set");
  endtask

  task automatic t_fill_hits();
    for (int t = 1; t <= 16; t++) acc(t, 0);
    idle();
    check_all("R5 fill");
    acc(16, 0); bump(0);
    acc(1, 0);  bump(15);
    acc(2, 0);  bump(15);
    acc(15, 0); bump(3);
    idle();
    check_all("R4 R10 positions");
  endtask

  task automatic t_evict();
    acc(100, 0);
    acc(3, 0);
    acc(100, 0); bump(1);
    acc(4, 0);
    acc(3, 0);   bump(2);
    idle();
    check_all("R5 eviction");
  endtask

  task automatic t_ignored();
    acc(15, 0, 1, 1);
    acc(15, 0, 0, 0);
    idle();
    check_all("R2 R3 ignored");
    acc(15, 0); bump(3);
    idle();
    check_all("R2 R3 order kept");
  endtask

  task automatic t_indep();
    acc(15, 1);
    acc(15, 1); bump(0);
    acc(3, 0);  bump(1);
    idle();
    check_all("R6 independent sets");
  endtask

  task automatic t_b2b();
    acc(7, 2);
    acc(8, 2);
    acc(7, 2); bump(1);
    acc(8, 2); bump(1);
    acc(7, 2); bump(1);
    idle();
    check_all("R9 back-to-back");
  endtask

  task automatic t_sat();
    @(negedge clk);
    acc_valid = 0; cnt_clear = 1;
    idle();
    for (int p = 0; p < WAYS; p++) expc[p] = 0;
    check_all("R8 clear");
    for (int i = 0; i < 40; i++) begin
      acc(7, 2); bump(0);
    end
    idle();
    check_all("R7 saturate");
    acc(7, 2); bump(0);
    idle();
    check_all("R7 hold at max");
  endtask

  task automatic t_clear_prio();
    acc(7, 2);
    cnt_clear = 1;
    idle();
    for (int p = 0; p < WAYS; p++) expc[p] = 0;
    check_all("R8 clear wins");
    acc(8, 2); bump(1);
    idle();
    check_all("R8 tags kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_hits();
    t_evict();
    t_ignored();
    t_indep();
    t_b2b();
    t_sat();
    t_clear_prio();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule